// File: doc/BRIEF.md
# Partitioned State Machine with Sub-Machine Sleep Control

This block is a small finite state machine whose eight states are split into two halves. Each half has its own next-state and output logic. The top bit of the present state decides which half is live. The live half computes the next state and the outputs. The idle half is kept quiet: its inputs are frozen by hold stages, and its sleep signal stays asserted. A single 3-bit register holds the state for both halves. A 2:1 multiplexer, steered by the same top bit, picks the next state and the outputs of the live half.

The sleep outputs model the enables of power switches. They are combinational in the clock. Under the normal test-enable setting (`test_en_a` low, `test_en_b` high):

- the live half is awake only while the clock is low;
- the idle half is asleep in both clock phases.

The present state can be forced from outside. While `seed_load` is high, the value on `seed_state` replaces the registered state as the present state. When `seed_load` drops, the registered next state feeds back again.

Top module: `split_fsm`

## Requirements
- R1: A synchronous active-high `rst` clears the state register to 000 and clears both input-hold stages. With `seed_load` low, `state_out` therefore reads 000 and `dout` reads 00 after a reset edge.
- R2: In states 000 to 011, the first half sets the next state as follows (din=0 / din=1): 000→001/010, 001→000/011, 010→010/100, 011→101/001.
- R3: In states 100 to 111, the second half sets the next state as follows (din=0 / din=1): 100→101/110, 101→100/000, 110→111/010, 111→100/111.
- R4: `dout` is the output of the half selected by state bit 2. The first half gives 000→00, 001→01, 010→10, 011→11. The second half gives 100→10, 101→01, 110→11, 111→00.
- R5: While the state's top bit selects one half, the held inputs of the other half do not change. When control returns to a half, that half resumes correctly.
- R6: `sleep_a` equals (state bit 2) OR clk OR `test_en_a`. A value of 1 means gated off.
- R7: `sleep_b` equals (NOT state bit 2 OR clk) AND `test_en_b`. A value of 1 means gated off.
- R8: While `seed_load` is high, `state_out` and `dout` follow `seed_state`. The register captures the next state of that seed at the rising edge.
- R9: The state register changes only on the rising clock edge. `state_out` is stable through the high and low phases of a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; the register updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| seed_load | input | 1 | Selects `seed_state` as the present state |
| seed_state | input | 3 | External present-state seed |
| din | input | 1 | Primary input to the machine |
| test_en_a | input | 1 | Test enable for the first half's sleep |
| test_en_b | input | 1 | Test enable for the second half's sleep |
| state_out | output | 3 | Present state (seed or registered) |
| dout | output | 2 | Output of the selected half |
| sleep_a | output | 1 | First half gated off when 1 |
| sleep_b | output | 1 | Second half gated off when 1 |

## Verification
The block has no parameters, so the bench builds it as it stands with its fixed eight-state table. A walk of sixteen inputs covers every state and every cross-partition edge, in both directions. At each step the bench samples the sleep signals in the high and the low clock phase. It also runs directed tests for the seed load, both test-enable overrides and a reset in the middle of a run.

// File: rtl/split_fsm.sv
module split_fsm (
  input  logic       clk,
  input  logic       rst,
  input  logic       seed_load,
  input  logic [2:0] seed_state,
  input  logic       din,
  input  logic       test_en_a,
  input  logic       test_en_b,
  output logic [2:0] state_out,
  output logic [1:0] dout,
  output logic       sleep_a,
  output logic       sleep_b
);
  logic [2:0] st_q, ps, nxt, nxt_a, nxt_b;
  logic [2:0] a_hold, b_hold, a_in, b_in;
  logic [1:0] out_a, out_b;
  logic       part;

  assign ps        = seed_load ? seed_state : st_q;
  assign part      = ps[2];
  assign state_out = ps;

  assign a_in = part ? a_hold : {ps[1:0], din};
  assign b_in = part ? {ps[1:0], din} : b_hold;

  always_comb begin
    case (a_in[2:1])
      2'd0:    begin nxt_a = a_in[0] ? 3'd2 : 3'd1; out_a = 2'b00; end
      2'd1:    begin nxt_a = a_in[0] ? 3'd3 : 3'd0; out_a = 2'b01; end
      2'd2:    begin nxt_a = a_in[0] ? 3'd4 : 3'd2; out_a = 2'b10; end
      default: begin nxt_a = a_in[0] ? 3'd1 : 3'd5; out_a = 2'b11; end
    endcase
  end

  always_comb begin
    case (b_in[2:1])
      2'd0:    begin nxt_b = b_in[0] ? 3'd6 : 3'd5; out_b = 2'b10; end
      2'd1:    begin nxt_b = b_in[0] ? 3'd0 : 3'd4; out_b = 2'b01; end
      2'd2:    begin nxt_b = b_in[0] ? 3'd2 : 3'd7; out_b = 2'b11; end
      default: begin nxt_b = b_in[0] ? 3'd7 : 3'd4; out_b = 2'b00; end
    endcase
  end

  assign nxt  = part ? nxt_b : nxt_a;
  assign dout = part ? out_b : out_a;

  assign sleep_a = part | clk | test_en_a;
  assign sleep_b = (~part | clk) & test_en_b;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= 3'd0;
      a_hold <= 3'd0;
      b_hold <= 3'd0;
    end else begin
      st_q   <= nxt;
      a_hold <= a_in;
      b_hold <= b_in;
    end
  end
endmodule

// File: rtl/split_fsm_chk.sv
module split_fsm_chk (
  input logic       clk,
  input logic       rst,
  input logic       seed_load,
  input logic       din,
  input logic [2:0] state_out,
  input logic [1:0] dout,
  input logic [2:0] a_hold,
  input logic [2:0] b_hold
);
  AST_RESET_ZERO: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (seed_load || state_out == 3'd0)); // R1
  AST_A_CROSS: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && state_out == 3'd3 && !din) |=> (seed_load || state_out == 3'd5)); // R2
  AST_B_CROSS: assert property (@(posedge clk) disable iff (rst)
    (!seed_load && state_out == 3'd5 && din) |=> (seed_load || state_out == 3'd0)); // R3
  AST_OUT_SEL: assert property (@(posedge clk) disable iff (rst)
    (state_out == 3'd6) |-> (dout == 2'b11)); // R4
  AST_HOLD_A: assert property (@(posedge clk) disable iff (rst)
    state_out[2] |=> (a_hold == $past(a_hold))); // R5
  AST_HOLD_B: assert property (@(posedge clk) disable iff (rst)
    !state_out[2] |=> (b_hold == $past(b_hold))); // R5
endmodule

bind split_fsm split_fsm_chk chk (
  .clk(clk), .rst(rst), .seed_load(seed_load), .din(din),
  .state_out(state_out), .dout(dout), .a_hold(a_hold), .b_hold(b_hold)
);

// File: tb/split_fsm_test.sv
module split_fsm_test;
  logic clk = 1'b0, rst = 1'b1, seed_load = 1'b0, din = 1'b0;
  logic test_en_a = 1'b0, test_en_b = 1'b1;
  logic [2:0] seed_state = 3'd0;
  logic [2:0] state_out;
  logic [1:0] dout;
  logic sleep_a, sleep_b;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  split_fsm uut (.clk(clk), .rst(rst), .seed_load(seed_load), .seed_state(seed_state),
    .din(din), .test_en_a(test_en_a), .test_en_b(test_en_b), .state_out(state_out),
    .dout(dout), .sleep_a(sleep_a), .sleep_b(sleep_b));

  // {din, expected state after the edge, expected dout}
  localparam logic [5:0] VEC [16] = '{
    {1'b1,3'd2,2'b10}, {1'b1,3'd4,2'b10}, {1'b0,3'd5,2'b01}, {1'b1,3'd0,2'b00},
    {1'b0,3'd1,2'b01}, {1'b1,3'd3,2'b11}, {1'b0,3'd5,2'b01}, {1'b0,3'd4,2'b10},
    {1'b1,3'd6,2'b11}, {1'b1,3'd2,2'b10}, {1'b0,3'd2,2'b10}, {1'b1,3'd4,2'b10},
    {1'b1,3'd6,2'b11}, {1'b0,3'd7,2'b00}, {1'b1,3'd7,2'b00}, {1'b0,3'd4,2'b10}};

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input logic d);
    din = d;
    @(posedge clk); #2;
    chk("R6 high phase sleep_a", sleep_a, 1);
    chk("R7 high phase sleep_b", sleep_b, 1);
    @(negedge clk); #1;
  endtask

  initial begin
    fork
      begin
        repeat (2) @(posedge clk);
        @(negedge clk); rst = 1'b0; #1;
        chk("R1 reset state", state_out, 0);
        chk("R1 reset dout", dout, 0);
        chk("R6 low phase sleep_a in first half", sleep_a, 0);
        chk("R7 low phase sleep_b in first half", sleep_b, 1);
        for (int i = 0; i < 16; i++) begin
          automatic logic [2:0] prev = state_out;
          automatic logic [2:0] mid;
          din = VEC[i][5];
          @(posedge clk); #2;
          mid = state_out;
          chk("R6 high phase sleep_a", sleep_a, 1);
          chk("R7 high phase sleep_b", sleep_b, 1);
          @(negedge clk); #1;
          chk("R9 state stable across phases", state_out, mid);
          if (prev[2] && !VEC[i][4]) chk("R5 return to first half", state_out, VEC[i][4:2]);
          else if (prev[2]) chk("R3 second half transition", state_out, VEC[i][4:2]);
          else chk("R2 first half transition", state_out, VEC[i][4:2]);
          chk("R4 output select", dout, VEC[i][1:0]);
          chk("R6 low phase sleep_a", sleep_a, VEC[i][4] ? 1 : 0);
          chk("R7 low phase sleep_b", sleep_b, VEC[i][4] ? 0 : 1);
        end
        // seed load
        seed_load = 1'b1; seed_state = 3'd6; #1;
        chk("R8 seed as present state", state_out, 6);
        chk("R8 seed output", dout, 3);
        step(1'b0);
        seed_load = 1'b0; #1;
        chk("R8 registered next of seed", state_out, 7);
        chk("R4 output after seed", dout, 0);
        // test enables
        rst = 1'b1; @(posedge clk); @(negedge clk); rst = 1'b0; #1;
        chk("R1 reset mid run", state_out, 0);
        test_en_a = 1'b1; #1;
        chk("R6 test_en_a forces sleep", sleep_a, 1);
        test_en_a = 1'b0; test_en_b = 1'b0; #1;
        chk("R7 test_en_b low wakes second half", sleep_b, 0);
        @(posedge clk); #2;
        chk("R7 test_en_b low in high phase", sleep_b, 0);
        @(negedge clk); #1;
        test_en_b = 1'b1;
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule